// File: doc/BRIEF.md
# External Interrupt Detect Channel

This block watches a set of asynchronous interrupt pins, one channel per pin, and turns the condition seen on each pin into a per-channel status flag. Each pin passes through a two-stage synchronizer clocked by the sampling clock. It can then pass through a 2-of-3 majority vote that suppresses short spikes. After that a detector compares the sample against the channel's chosen condition: high level, low level, rising edge or falling edge.

The status flags drive two outputs. The request output goes to an interrupt controller and honours a per-channel mask. The wake output ignores the mask, so a masked channel can still bring a sleeping system back. Software sets up the channels through a small write-only register port. Enable and disable are set and clear strobes. Mask, filter and mode are plain vectors. Edge flags are cleared by writing ones to a clear address.

Top module: `extirq_detect`

## Requirements
- R1: After reset the status vector, `irq_o` and `wake_o` are zero, and every channel is disabled, unmasked, unfiltered and in falling-edge mode.
- R2: With the filter off, a pin change that is stable before a rising clock edge shows in the status flag after the third rising edge (two synchronizer stages and the status register).
- R3: With the channel's filter bit set, the same change shows one edge later, after the fourth rising edge.
- R4: With the filter on, a pin pulse that lasts one sampling cycle never sets the flag. A pulse that lasts two sampling cycles sets it.
- R5: A channel whose enable is clear keeps its status bit at zero at all times, even when its pin condition holds.
- R6: Writing a one for a channel at the disable address clears both its enable and its status bit on that clock edge.
- R7: A masked, enabled channel still sets its status bit and drives `wake_o`. It only withholds `irq_o`.
- R8: In level mode the status bit follows the detected level one edge later. A clear write has no effect on it while the level holds, and it drops after the third edge once the pin leaves the level.
- R9: In edge mode a rising edge (polarity 1) or a falling edge (polarity 0) sets the status bit. The bit stays set until a one is written for that channel at the clear address.
- R10: `irq_o` is high when any status bit is set with its mask bit clear. `wake_o` is high when any status bit is set.
- R11: Register writes take effect on the rising edge where `wr_en_i` is high. The addresses are: 0 enable-set, 1 disable, 2 mask (1 = masked), 3 filter (1 = on), 4 type (1 = level, 0 = edge), 5 polarity (1 = high/rising, 0 = low/falling), 6 status clear (write one to clear). Bit n of `wr_data_i` addresses channel n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NCH | Asynchronous interrupt pins, one per channel |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | NCH | Write data, one bit per channel |
| status_o | output | NCH | Per-channel status flags |
| irq_o | output | 1 | Request to the interrupt controller |
| wake_o | output | 1 | Wake indication, ignores the mask |

## Verification
The bound checker checks four rules on every cycle. A disabled channel never holds status. A disable write leaves the addressed flags clear on the next edge. A status bit rises only after the detector fired in the previous cycle. Edge flags stay set and level flags track the detector while no write is in progress. The checker also checks every cycle that the request and wake outputs agree with the status flags and the mask.

The exact latency in edges, with the filter on and off, and the rejection of one-cycle spikes depend on pin timing. Only the directed scenarios can show these, and the same holds for the four detect conditions and for the clear writes that are ignored in level mode.

// File: rtl/extirq_pkg.sv
package extirq_pkg;
  localparam int REG_AW = 3;
  localparam logic [REG_AW-1:0] A_ENSET = 3'd0;
  localparam logic [REG_AW-1:0] A_DIS   = 3'd1;
  localparam logic [REG_AW-1:0] A_MASK  = 3'd2;
  localparam logic [REG_AW-1:0] A_FILT  = 3'd3;
  localparam logic [REG_AW-1:0] A_TYPE  = 3'd4;
  localparam logic [REG_AW-1:0] A_POL   = 3'd5;
  localparam logic [REG_AW-1:0] A_CLR   = 3'd6;

  // 2-of-3 majority vote
  function automatic logic vote3(input logic [2:0] v);
    return (v[0] & v[1]) | (v[0] & v[2]) | (v[1] & v[2]);
  endfunction

  // Detect condition: lvl=1 level, pol=1 high/rising
  function automatic logic detect(input logic lvl, input logic pol,
                                  input logic cur, input logic prev);
    if (lvl) return pol ? cur : ~cur;
    else     return pol ? (cur & ~prev) : (~cur & prev);
  endfunction
endpackage

// File: rtl/extirq_sync.sv
module extirq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic filt_en_i,
  output logic sample_o
);
  import extirq_pkg::*;
  localparam int HIST = 2;

  logic [STAGES-1:0] chain_q;
  logic [HIST-1:0]   hist_q;
  logic              sync_val;

  assign sync_val = chain_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      hist_q  <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], pin_i};
      hist_q  <= {hist_q[HIST-2:0], sync_val};
    end
  end

  assign sample_o = filt_en_i ? vote3({sync_val, hist_q}) : sync_val;
endmodule

// File: rtl/extirq_regs.sv
module extirq_regs #(
  parameter int NCH = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en_i,
  input  logic [extirq_pkg::REG_AW-1:0] wr_addr_i,
  input  logic [NCH-1:0]                wr_data_i,
  output logic [NCH-1:0]                en_o,
  output logic [NCH-1:0]                mask_o,
  output logic [NCH-1:0]                filt_o,
  output logic [NCH-1:0]                lvl_o,
  output logic [NCH-1:0]                pol_o,
  output logic [NCH-1:0]                dis_stb_o,
  output logic [NCH-1:0]                clr_stb_o
);
  import extirq_pkg::*;

  logic hit_en, hit_dis;
  assign hit_en  = wr_en_i && (wr_addr_i == A_ENSET);
  assign hit_dis = wr_en_i && (wr_addr_i == A_DIS);

  assign dis_stb_o = hit_dis ? wr_data_i : '0;
  assign clr_stb_o = (wr_en_i && (wr_addr_i == A_CLR)) ? wr_data_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_o   <= '0;
      mask_o <= '0;
      filt_o <= '0;
      lvl_o  <= '0;
      pol_o  <= '0;
    end else begin
      if (hit_en)  en_o <= en_o | wr_data_i;
      if (hit_dis) en_o <= en_o & ~wr_data_i;
      if (wr_en_i && wr_addr_i == A_MASK) mask_o <= wr_data_i;
      if (wr_en_i && wr_addr_i == A_FILT) filt_o <= wr_data_i;
      if (wr_en_i && wr_addr_i == A_TYPE) lvl_o  <= wr_data_i;
      if (wr_en_i && wr_addr_i == A_POL)  pol_o  <= wr_data_i;
    end
  end
endmodule

// File: rtl/extirq_chan.sv
module extirq_chan (
  input  logic clk,
  input  logic rst_n,
  input  logic sample_i,
  input  logic en_i,
  input  logic lvl_i,
  input  logic pol_i,
  input  logic dis_i,
  input  logic clr_i,
  output logic hit_o,
  output logic status_o
);
  import extirq_pkg::*;

  logic prev_q;
  logic status_d;

  assign hit_o = detect(lvl_i, pol_i, sample_i, prev_q);

  always_comb begin
    if (dis_i || !en_i) status_d = 1'b0;
    else if (lvl_i)     status_d = hit_o;
    else                status_d = hit_o | (status_o & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= 1'b0;
      status_o <= 1'b0;
    end else begin
      prev_q   <= sample_i;
      status_o <= status_d;
    end
  end
endmodule

// File: rtl/extirq_detect.sv
module extirq_detect #(
  parameter int NCH         = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NCH-1:0]                pin_i,
  input  logic                          wr_en_i,
  input  logic [extirq_pkg::REG_AW-1:0] wr_addr_i,
  input  logic [NCH-1:0]                wr_data_i,
  output logic [NCH-1:0]                status_o,
  output logic                          irq_o,
  output logic                          wake_o
);
  logic [NCH-1:0] en_q, mask_q, filt_q, lvl_q, pol_q;
  logic [NCH-1:0] dis_stb, clr_stb;
  logic [NCH-1:0] sample_vec;
  logic [NCH-1:0] hit_vec;

  extirq_regs #(.NCH(NCH)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .en_o(en_q), .mask_o(mask_q), .filt_o(filt_q), .lvl_o(lvl_q), .pol_o(pol_q),
    .dis_stb_o(dis_stb), .clr_stb_o(clr_stb)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    extirq_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin_i(pin_i[i]),
      .filt_en_i(filt_q[i]), .sample_o(sample_vec[i])
    );
    extirq_chan u_chan (
      .clk(clk), .rst_n(rst_n), .sample_i(sample_vec[i]),
      .en_i(en_q[i]), .lvl_i(lvl_q[i]), .pol_i(pol_q[i]),
      .dis_i(dis_stb[i]), .clr_i(clr_stb[i]),
      .hit_o(hit_vec[i]), .status_o(status_o[i])
    );
  end

  assign irq_o  = |(status_o & ~mask_q);
  assign wake_o = |status_o;
endmodule

// File: rtl/extirq_detect_chk.sv
module extirq_detect_chk #(
  parameter int NCH = 4
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          wr_en_i,
  input logic [extirq_pkg::REG_AW-1:0] wr_addr_i,
  input logic [NCH-1:0]                wr_data_i,
  input logic [NCH-1:0]                status_o,
  input logic                          irq_o,
  input logic                          wake_o,
  input logic [NCH-1:0]                en_q,
  input logic [NCH-1:0]                mask_q,
  input logic [NCH-1:0]                lvl_q,
  input logic [NCH-1:0]                hit_vec
);
  import extirq_pkg::*;

  p_off_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o & ~en_q) == '0);

  p_dis_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_addr_i == A_DIS) |=> ((status_o & $past(wr_data_i)) == '0));

  p_masked_wake_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_o & mask_q) != '0 && (status_o & ~mask_q) == '0) |-> (wake_o && !irq_o));

  p_set_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_o & ~$past(status_o) & ~$past(hit_vec)) == '0));

  p_level_track_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> (($past(en_q) & $past(lvl_q) & (status_o ^ $past(hit_vec))) == '0));

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> (($past(status_o) & $past(en_q) & ~$past(lvl_q) & ~status_o) == '0));

  p_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_o & ~mask_q) != '0) |-> (irq_o && wake_o));

  p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o == '0) |-> (!irq_o && !wake_o));
endmodule

bind extirq_detect extirq_detect_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
  .wr_data_i(wr_data_i), .status_o(status_o), .irq_o(irq_o), .wake_o(wake_o),
  .en_q(en_q), .mask_q(mask_q), .lvl_q(lvl_q), .hit_vec(hit_vec)
);

// File: tb/tb_extirq_detect.sv
`timescale 1ns/1ps
module tb_extirq_detect;
  localparam int NCH = 4;
  localparam logic [2:0] W_ENSET = 3'd0, W_DIS = 3'd1, W_MASK = 3'd2,
                         W_FILT = 3'd3, W_TYPE = 3'd4, W_POL = 3'd5, W_CLR = 3'd6;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NCH-1:0] pin = '0;
  logic           wr_en = 1'b0;
  logic [2:0]     wr_addr = '0;
  logic [NCH-1:0] wr_data = '0;
  logic [NCH-1:0] status;
  logic           irq, wake;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  extirq_detect #(.NCH(NCH)) dut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .status_o(status), .irq_o(irq), .wake_o(wake)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic wr(input logic [2:0] a, input logic [NCH-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset_cfg();
    chk("R1", "status", status, 0);
    chk("R1", "irq", irq, 0);
    chk("R1", "wake", wake, 0);
    // ch0 level high, ch1 rising filtered, ch2 falling, ch3 level low
    wr(W_TYPE, 4'b1001);
    wr(W_POL,  4'b0011);
    wr(W_FILT, 4'b0010);
    wait_n(4);
    chk("R5", "disabled low-level ch3", status, 0);
  endtask

  task automatic t_latency_level();
    wr(W_ENSET, 4'b0001);
    pin[0] = 1'b1;
    wait_n(2);
    chk("R2", "ch0 after 2 edges", status[0], 0);
    wait_n(1);
    chk("R2", "ch0 after 3 edges", status[0], 1);
    chk("R10", "irq", irq, 1);
    chk("R10", "wake", wake, 1);
    wr(W_CLR, 4'b0001);
    chk("R8", "clear ignored on level", status[0], 1);
    pin[0] = 1'b0;
    wait_n(2);
    chk("R8", "level still held", status[0], 1);
    wait_n(1);
    chk("R8", "level dropped", status[0], 0);
  endtask

  task automatic t_filter_edge();
    wr(W_ENSET, 4'b0010);
    pin[1] = 1'b1;
    wait_n(3);
    chk("R3", "ch1 after 3 edges", status[1], 0);
    wait_n(1);
    chk("R3", "ch1 after 4 edges", status[1], 1);
    pin[1] = 1'b0;
    wait_n(5);
    chk("R9", "rising flag sticky", status[1], 1);
    wr(W_CLR, 4'b0010);
    chk("R9", "cleared by write", status[1], 0);
  endtask

  task automatic t_glitch();
    pin[1] = 1'b1; wait_n(1); pin[1] = 1'b0;
    wait_n(6);
    chk("R4", "one-cycle pulse rejected", status[1], 0);
    pin[1] = 1'b1; wait_n(2); pin[1] = 1'b0;
    wait_n(6);
    chk("R4", "two-cycle pulse accepted", status[1], 1);
    wr(W_CLR, 4'b0010);
  endtask

  task automatic t_falling();
    wr(W_ENSET, 4'b0100);
    pin[2] = 1'b1;
    wait_n(5);
    chk("R9", "rise ignored in falling mode", status[2], 0);
    pin[2] = 1'b0;
    wait_n(2);
    chk("R9", "fall after 2 edges", status[2], 0);
    wait_n(1);
    chk("R9", "fall after 3 edges", status[2], 1);
  endtask

  task automatic t_low_mask();
    wr(W_ENSET, 4'b1000);
    wait_n(1);
    chk("R8", "low level on enable", status[3], 1);
    wr(W_CLR, 4'b0111);
    chk("R11", "clear vector", status, 4'b1000);
    wr(W_MASK, 4'b1000);
    chk("R7", "masked status", status[3], 1);
    chk("R7", "masked irq", irq, 0);
    chk("R7", "masked wake", wake, 1);
    pin[0] = 1'b1;
    wait_n(3);
    chk("R10", "unmasked ch0 drives irq", irq, 1);
    pin[0] = 1'b0;
    wait_n(3);
    chk("R10", "irq gone with ch0", irq, 0);
    wr(W_MASK, 4'b0000);
    chk("R10", "unmask ch3", irq, 1);
  endtask

  task automatic t_disable();
    wr(W_DIS, 4'b1000);
    chk("R6", "status cleared", status, 0);
    chk("R6", "wake low", wake, 0);
    chk("R6", "irq low", irq, 0);
    wait_n(5);
    chk("R5", "disabled ch3 stays clear", status[3], 0);
    wr(W_ENSET, 4'b1000);
    wait_n(1);
    chk("R6", "re-enabled ch3", status[3], 1);
  endtask

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);
    t_reset_cfg();
    t_latency_level();
    t_filter_edge();
    t_glitch();
    t_falling();
    t_low_mask();
    t_disable();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule